// File: doc/BRIEF.md
# Flooding Min-Sum LDPC Decode Sequencer

This block runs the iteration loop of a min-sum LDPC decoder with a flooding schedule. One frame of N soft channel values (log-likelihood ratios, LLRs) arrives as a packed vector through a valid/ready handshake. The block then runs one setup cycle followed by whole iterations. Each iteration updates every variable node, then every check node, and then tests the parity of the tentative hard decisions. Decoding stops at the first iteration whose decisions satisfy every parity check, or when the iteration budget given with the frame is used up. The parity-check matrix is a fixed parameter. The default is a 3x7 single-error-correcting code.

The block holds all check-to-variable messages in registers. It clears that storage during setup and treats the messages as zero during the first variable-node pass. When a decode ends, the hard decisions, a converged flag and the iteration count are registered and held until the next frame is accepted. A one-cycle done pulse marks the moment they become valid. Back-pressure is simple: `in_ready` is high only while the block is idle. A source holding `in_valid` high must keep `llr_in` and `max_iter` stable until it sees `in_ready`. Both are sampled on the cycle where `in_valid` and `in_ready` are both high.

Top module: `ldpc_dec_ctrl`

## Requirements
- R1: LLR n sits at bits [n*Q +: Q] of `llr_in` as a Q-bit two's-complement value, where a negative value favours bit 1. A frame is taken on a clock edge with `in_valid` and `in_ready` both high. `in_ready` is high only in the idle state and drops on the cycle after a frame is taken.
- R2: A setup cycle follows each accepted frame and clears all check-to-variable messages. The first variable-node pass uses zero for every incoming check message, so a frame's result never depends on earlier frames.
- R3: Each variable node forms a posterior: its LLR plus the sum of the check messages on its connected edges. The message it sends to check m is the posterior minus the message from m, saturated to the range -(2^(Q-1)-1) to +(2^(Q-1)-1).
- R4: Each check node sends to variable n the smallest magnitude among the messages from its other connected variables. The sign is negative when an odd number of those messages are negative, and a zero message counts as positive.
- R5: The hard decision for bit n is 1 exactly when its posterior is negative. After each iteration, the block declares the frame converged when every row of the parity-check matrix has even parity over the hard decisions.
- R6: If the block has not converged by then, it stops after `max_iter` iterations (a value of 0 acts as 1). In that case `converged` is low and `iters` equals the budget.
- R7: `done` is high for exactly one cycle. It rises 3k+1 clock edges after the accepting edge, where k is the number of iterations used.
- R8: `hard`, `converged` and `iters` change only when `done` rises, and they hold while the block is idle. The exception is `converged`, which clears on the edge that accepts the next frame.
- R9: Frames offered back to back without a reset each decode to the same result they would give alone.
- R10: After reset, `in_ready` is 1 and `done`, `converged`, `iters` and `hard` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Frame offered |
| in_ready | output | 1 | Block is idle and takes the frame |
| llr_in | input | N*Q | Packed channel LLRs |
| max_iter | input | IW | Iteration budget for the offered frame |
| done | output | 1 | One-cycle pulse when a decode ends |
| converged | output | 1 | Last decode satisfied every parity check |
| hard | output | N | Hard decisions of the last decode |
| iters | output | IW | Iterations used by the last decode |

## Verification
The decoder is tried with several kinds of frame. A strong, noiseless codeword with mixed ones and zeros checks the sign convention and the single-iteration exit. A codeword with one weak, wrong LLR can only be corrected by the check-node min/sign rule. A frame that settles into a two-iteration oscillation is run with budgets of 8, 3 and 0. It separates an exit on the budget from an exit on convergence, and the odd and even budgets land on different hard patterns. Pseudo-random frames sent back to back, with a stale message state between them, expose any leftover coupling between frames and any back-pressure fault. The results are compared against a reference model built into the bench.

// File: rtl/ldpc_pkg.sv
package ldpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_VN,
    ST_CN,
    ST_CHK,
    ST_DONE
  } dec_state_e;
endpackage

// File: rtl/ldpc_vn_array.sv
module ldpc_vn_array #(
  parameter int N = 7,
  parameter int M = 3,
  parameter int Q = 6,
  parameter logic [M*N-1:0] H = 21'b1111000_1100110_1010101
) (
  input  logic [N*Q-1:0]   llr,
  input  logic [M*N*Q-1:0] c2v,
  input  logic             bypass,
  output logic [M*N*Q-1:0] v2c,
  output logic [N-1:0]     neg
);
  localparam int PW = Q + $clog2(M + 1) + 1;
  localparam logic signed [PW-1:0] VMAX = PW'(2 ** (Q - 1) - 1);
  localparam logic signed [PW-1:0] VMIN = -VMAX;

  for (genvar n = 0; n < N; n++) begin : g_var
    logic signed [PW-1:0] tot;

    always_comb begin
      tot = PW'($signed(llr[n*Q +: Q]));
      for (int m = 0; m < M; m++) begin
        if (H[m*N+n] && !bypass) tot = tot + PW'($signed(c2v[(m*N+n)*Q +: Q]));
      end
    end

    assign neg[n] = tot[PW-1];

    for (genvar m = 0; m < M; m++) begin : g_edge
      logic [Q-1:0] val;
      if (H[m*N+n]) begin : g_on
        logic signed [PW-1:0] cm;
        logic signed [PW-1:0] ext;
        always_comb begin
          cm = PW'($signed(c2v[(m*N+n)*Q +: Q]));
          if (bypass) cm = '0;
          ext = tot - cm;
          if (ext > VMAX)      val = VMAX[Q-1:0];
          else if (ext < VMIN) val = VMIN[Q-1:0];
          else                 val = ext[Q-1:0];
        end
      end else begin : g_off
        assign val = VMAX[Q-1:0];
      end
      assign v2c[(m*N+n)*Q +: Q] = val;
    end
  end
endmodule

// File: rtl/ldpc_cn_array.sv
module ldpc_cn_array #(
  parameter int N = 7,
  parameter int M = 3,
  parameter int Q = 6,
  parameter logic [M*N-1:0] H = 21'b1111000_1100110_1010101
) (
  input  logic [M*N*Q-1:0] v2c,
  output logic [M*N*Q-1:0] c2v
);
  localparam logic [Q-1:0] MAGMAX = Q'(2 ** (Q - 1) - 1);

  for (genvar m = 0; m < M; m++) begin : g_chk
    for (genvar n = 0; n < N; n++) begin : g_edge
      logic [Q-1:0] val;
      if (H[m*N+n]) begin : g_on
        logic         sgn;
        logic [Q-1:0] mn;
        logic [Q-1:0] v;
        logic [Q-1:0] a;
        always_comb begin
          sgn = 1'b0;
          mn  = MAGMAX;
          v   = '0;
          a   = '0;
          for (int k = 0; k < N; k++) begin
            if (k != n) begin
              v   = v2c[(m*N+k)*Q +: Q];
              sgn = sgn ^ v[Q-1];
              a   = v[Q-1] ? (~v + 1'b1) : v;
              if (a < mn) mn = a;
            end
          end
          val = sgn ? (~mn + 1'b1) : mn;
        end
      end else begin : g_off
        assign val = '0;
      end
      assign c2v[(m*N+n)*Q +: Q] = val;
    end
  end
endmodule

// File: rtl/ldpc_parity.sv
module ldpc_parity #(
  parameter int N = 7,
  parameter int M = 3,
  parameter logic [M*N-1:0] H = 21'b1111000_1100110_1010101
) (
  input  logic [N-1:0] bits,
  output logic [M-1:0] syn
);
  for (genvar m = 0; m < M; m++) begin : g_row
    assign syn[m] = ^(bits & H[m*N +: N]);
  end
endmodule

// File: rtl/ldpc_dec_ctrl.sv
module ldpc_dec_ctrl
  import ldpc_pkg::*;
#(
  parameter int N  = 7,
  parameter int M  = 3,
  parameter int Q  = 6,
  parameter int IW = 8,
  parameter logic [M*N-1:0] H = 21'b1111000_1100110_1010101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N*Q-1:0] llr_in,
  input  logic [IW-1:0] max_iter,
  output logic          done,
  output logic          converged,
  output logic [N-1:0]  hard,
  output logic [IW-1:0] iters
);
  localparam int EDGES = M * N;
  localparam int EW    = EDGES * Q;

  dec_state_e     st;
  logic [N*Q-1:0] llr_q;
  logic [EW-1:0]  c2v_q, v2c_q, v2c_w, c2v_w;
  logic [N-1:0]   hard_w, hard_q;
  logic [M-1:0]   syn_w;
  logic           first_q, done_q, conv_q;
  logic [IW-1:0]  it_q, max_q, iters_q;
  logic           accept, stop;

  ldpc_vn_array #(.N(N), .M(M), .Q(Q), .H(H)) u_vn (
    .llr(llr_q), .c2v(c2v_q), .bypass(first_q), .v2c(v2c_w), .neg(hard_w)
  );

  ldpc_cn_array #(.N(N), .M(M), .Q(Q), .H(H)) u_cn (
    .v2c(v2c_q), .c2v(c2v_w)
  );

  ldpc_parity #(.N(N), .M(M), .H(H)) u_par (
    .bits(hard_w), .syn(syn_w)
  );

  assign in_ready  = (st == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign stop      = (syn_w == '0) || (it_q >= max_q);
  assign done      = done_q;
  assign converged = conv_q;
  assign hard      = hard_q;
  assign iters     = iters_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      llr_q   <= '0;
      c2v_q   <= '0;
      v2c_q   <= '0;
      first_q <= 1'b1;
      it_q    <= '0;
      max_q   <= IW'(1);
      done_q  <= 1'b0;
      conv_q  <= 1'b0;
      hard_q  <= '0;
      iters_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            llr_q  <= llr_in;
            max_q  <= (max_iter == '0) ? IW'(1) : max_iter;
            conv_q <= 1'b0;
            st     <= ST_INIT;
          end
        end
        ST_INIT: begin
          for (int e = 0; e < EDGES; e++) c2v_q[e*Q +: Q] <= '0;
          first_q <= 1'b1;
          it_q    <= '0;
          st      <= ST_VN;
        end
        ST_VN: begin
          v2c_q   <= v2c_w;
          first_q <= 1'b0;
          st      <= ST_CN;
        end
        ST_CN: begin
          c2v_q <= c2v_w;
          it_q  <= it_q + 1'b1;
          st    <= ST_CHK;
        end
        ST_CHK: begin
          if (stop) begin
            hard_q  <= hard_w;
            conv_q  <= (syn_w == '0);
            iters_q <= it_q;
            done_q  <= 1'b1;
            st      <= ST_DONE;
          end else begin
            st <= ST_VN;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldpc_dec_ctrl_chk.sv
module ldpc_dec_ctrl_chk #(
  parameter int N  = 7,
  parameter int M  = 3,
  parameter int IW = 8,
  parameter logic [M*N-1:0] H = 21'b1111000_1100110_1010101
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          done,
  input logic          converged,
  input logic [N-1:0]  hard,
  input logic [IW-1:0] iters,
  input logic [IW-1:0] lim
);
  logic [M-1:0] par;
  for (genvar m = 0; m < M; m++) begin : g_par
    assign par[m] = ^(hard & H[m*N +: N]);
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  a_r8_conv_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !converged);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(hard) && $stable(converged) && $stable(iters)));

  a_r5_conv_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (done && converged) |-> (par == '0));

  a_r6_budget_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !converged) |-> (iters == lim));

  a_r6_within_budget: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (iters != '0 && iters <= lim));
endmodule

bind ldpc_dec_ctrl ldpc_dec_ctrl_chk #(.N(N), .M(M), .IW(IW), .H(H)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .converged(converged), .hard(hard), .iters(iters), .lim(max_q)
);

// File: tb/tb_ldpc_dec_ctrl.sv
`timescale 1ns/1ps
module tb_ldpc_dec_ctrl;
  localparam int N = 7, M = 3, Q = 6, IW = 8;
  localparam logic [M*N-1:0] HM = 21'b1111000_1100110_1010101;
  localparam int VMAX = 2 ** (Q - 1) - 1;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic in_ready, done, converged;
  logic [N*Q-1:0] llr_in = '0;
  logic [IW-1:0]  max_iter = '0;
  logic [N-1:0]   hard;
  logic [IW-1:0]  iters;

  ldpc_dec_ctrl #(.N(N), .M(M), .Q(Q), .IW(IW), .H(HM)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .llr_in(llr_in), .max_iter(max_iter), .done(done), .converged(converged),
    .hard(hard), .iters(iters)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  typedef struct {
    logic [N-1:0] h;
    logic         cv;
    int           it;
    int           acc;
    string        tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [N*Q-1:0] pk(input int v[N]);
    logic [N*Q-1:0] r;
    for (int n = 0; n < N; n++) r[n*Q +: Q] = Q'(v[n]);
    return r;
  endfunction

  // Reference model of R2-R6, written from the requirements
  task automatic ref_dec(input logic [N*Q-1:0] l, input int mx,
                         output logic [N-1:0] h, output logic cv, output int it);
    int L[N]; int c2v[M][N]; int v2c[M][N];
    int lim, tot, s, mn, a, v;
    bit par;
    lim = (mx == 0) ? 1 : mx;
    for (int n = 0; n < N; n++) L[n] = int'($signed(l[n*Q +: Q]));
    for (int m = 0; m < M; m++) for (int n = 0; n < N; n++) c2v[m][n] = 0;
    it = 0; cv = 0; h = '0;
    for (int k = 0; k < 256; k++) begin
      for (int n = 0; n < N; n++) begin
        tot = L[n];
        for (int m = 0; m < M; m++) if (HM[m*N+n]) tot += c2v[m][n];
        for (int m = 0; m < M; m++) begin
          if (HM[m*N+n]) begin
            v = tot - c2v[m][n];
            v2c[m][n] = (v > VMAX) ? VMAX : ((v < -VMAX) ? -VMAX : v);
          end else v2c[m][n] = VMAX;
        end
      end
      for (int m = 0; m < M; m++) for (int n = 0; n < N; n++) begin
        if (HM[m*N+n]) begin
          s = 0; mn = VMAX;
          for (int j = 0; j < N; j++) if (j != n) begin
            if (v2c[m][j] < 0) s ^= 1;
            a = (v2c[m][j] < 0) ? -v2c[m][j] : v2c[m][j];
            if (a < mn) mn = a;
          end
          c2v[m][n] = s ? -mn : mn;
        end else c2v[m][n] = 0;
      end
      it++;
      for (int n = 0; n < N; n++) begin
        tot = L[n];
        for (int m = 0; m < M; m++) if (HM[m*N+n]) tot += c2v[m][n];
        h[n] = (tot < 0);
      end
      cv = 1;
      for (int m = 0; m < M; m++) begin
        par = 0;
        for (int n = 0; n < N; n++) if (HM[m*N+n]) par ^= h[n];
        if (par) cv = 0;
      end
      if (cv || it >= lim) break;
    end
  endtask

  // Driver: offers one frame, pushes the expected result on acceptance
  task automatic decode(input logic [N*Q-1:0] l, input int mx, input string tag);
    exp_t e;
    ref_dec(l, mx, e.h, e.cv, e.it);
    e.tag = tag;
    @(negedge clk);
    in_valid = 1'b1; llr_in = l; max_iter = IW'(mx);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    e.acc = cyc;
    sb.push_back(e);
    check(converged == 1'b0, "R8", "converged after accept", int'(converged), 0);
    @(negedge clk);
    check(in_ready == 1'b0, "R1", "in_ready while busy", int'(in_ready), 0);
  endtask

  task automatic wait_idle();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops expectations as results appear
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb.size() == 0) check(0, "R7", "done with nothing pending", 1, 0);
        else begin
          e = sb.pop_front();
          check(hard == e.h, e.tag, "hard", int'(hard), int'(e.h));
          check(converged == e.cv, e.tag, "converged", int'(converged), int'(e.cv));
          check(int'(iters) == e.it, e.tag, "iters", int'(iters), e.it);
          check(cyc - e.acc == 3*e.it + 1, "R7", "done latency", cyc - e.acc, 3*e.it + 1);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      check(0, "WDOG", "watchdog expired", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cw[N], nz[N], osc[N], rv[N];
    logic [N-1:0] h0; logic [IW-1:0] i0;
    int unsigned seed;
    cw  = '{-12, 12, -12, 12, -12, 12, -12};
    nz  = '{-2, 10, 10, 10, 10, 10, 10};
    osc = '{1, 1, 1, 1, 1, 1, -5};

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R10", "reset in_ready", int'(in_ready), 1);
    check(done == 1'b0, "R10", "reset done", int'(done), 0);
    check(converged == 1'b0, "R10", "reset converged", int'(converged), 0);
    check(iters == '0, "R10", "reset iters", int'(iters), 0);
    check(hard == '0, "R10", "reset hard", int'(hard), 0);
    rst_n = 1'b1;

    decode(pk(cw), 8, "R5");                 // noiseless codeword 1010101
    wait_idle();
    check(hard == 7'b1010101, "R5", "codeword decisions", int'(hard), 'h55);
    check(iters == 8'd1, "R5", "codeword one iteration", int'(iters), 1);
    h0 = hard; i0 = iters;
    repeat (6) @(negedge clk);
    check(converged == 1'b1 && hard == h0 && iters == i0, "R8", "held while idle",
          int'(converged), 1);

    decode(pk(nz), 8, "R4");                 // one weak wrong bit, corrected
    wait_idle();
    check(hard == '0 && converged, "R4", "corrected to zero word", int'(hard), 0);

    decode(pk(osc), 8, "R6");                // oscillates, budget 8
    wait_idle();
    check(iters == 8'd8 && !converged, "R6", "budget 8 exhausted", int'(iters), 8);
    decode(pk(osc), 3, "R6");                // odd budget
    wait_idle();
    check(hard == 7'b1110100, "R3", "odd-iteration decisions", int'(hard), 'h74);
    decode(pk(osc), 0, "R6");                // zero acts as one
    wait_idle();
    check(iters == 8'd1, "R6", "zero budget acts as one", int'(iters), 1);

    // R2/R9: back to back after a non-converged run, with no reset between frames
    decode(pk(osc), 5, "R9");
    decode(pk(cw), 8, "R2");
    decode(pk(nz), 8, "R9");
    seed = 32'h1234567;
    for (int t = 0; t < 8; t++) begin
      for (int n = 0; n < N; n++) begin
        seed = seed * 1103515245 + 12345;
        rv[n] = int'((seed >> 16) % 25) - 12;
      end
      decode(pk(rv), 10, "R9");
    end
    wait_idle();
    check(sb.size() == 0, "R9", "all results returned", sb.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule